// File: doc/BRIEF.md
# Latched Four-Button Encoder

This block reads the four push buttons of a colour-matching game, one button under each coloured lamp. The first clean press, meaning exactly one button goes down, is captured and held until the controller issues a clear. Because the result is frozen until that clear, later contact bounce or extra presses cannot change it. The held press is reported as a 2-bit button number together with a flag that says a press is waiting.

Every raw input passes through a two-flop synchronizer before any decision is made. When a clear is issued, the buttons that are down at that moment are recorded in a mask. A masked button is ignored until its synchronized input reads released. This stops one long press from being counted twice across consecutive clears. A pattern with two or more unmasked buttons down is never captured.

Top module: `btn_latch_encoder`

## Requirements
- R1: After reset, `code_o` reads 00 and `pressed_o` is low.
- R2: A lone press of input bit i is reported as code i: bit 0 (pattern 0001) gives 00, bit 1 (0010) gives 01, bit 2 (0100) gives 10, bit 3 (1000) gives 11.
- R3: `pressed_o` rises, with the code valid, on the third rising clock edge after a lone unmasked press appears on `btn_i` (two synchronizer edges, then one capture edge).
- R4: An input pattern with more than one unmasked bit set, such as 1100, 1001, 0111 or 1111, is never captured.
- R5: While a press is held, `code_o` and `pressed_o` do not change on any input activity until a clear.
- R6: A clear returns `code_o` to 00 and `pressed_o` to low on the next edge, and a press present while the clear is high is not captured.
- R7: A button that is down when the clear is sampled is ignored until its synchronized input reads 0. After that release, a new press of the same button is accepted.
- R8: Masked buttons do not count toward the multi-press test. An unmasked lone press is accepted while a masked button is still held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the held press; records the buttons currently down as a mask |
| btn_i | input | 4 | Raw button levels, bit i high = button i down |
| code_o | output | 2 | Number of the held button |
| pressed_o | output | 1 | High while a press is held |

## Verification
On every cycle, the assertions check the following: a held press stays frozen, a clear empties the result one edge later, the code is 00 whenever no press is held, a lone unmasked press is captured on the next edge, and a multi-button pattern is never captured. They also check that the mask only ever shrinks, dropping bits whose synchronized input reads released. Only the bench scenarios can show the end-to-end three-edge latency from the pins and the exact code value for each button. They also show the release-then-repress sequence around a clear, and that a masked held button does not block a new lone press.

// File: rtl/btn_pkg.sv
package btn_pkg;
  localparam int MAX_BTN = 16;

  typedef logic [MAX_BTN-1:0] btn_vec_t;

  // True when exactly one bit of the pattern is set.
  function automatic logic is_single(input btn_vec_t v);
    return $countones(v) == 1;
  endfunction

  // Index of the highest set bit; 0 for an empty pattern.
  function automatic int unsigned bit_index(input btn_vec_t v);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < MAX_BTN; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/btn_mask.sv
module btn_mask #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (clear_i) mask_q <= sync_i;
    else              mask_q <= mask_q & sync_i;
  end

  assign mask_o = mask_q;

  // A bit may leave the mask only, never join it, outside a clear.
  AST_MASK_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (mask_q & ~$past(mask_q)) == '0); // R7
  // A bit whose synchronized input read released is unmasked.
  AST_MASK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (mask_q & ~$past(sync_i)) == '0); // R7
endmodule

// File: rtl/btn_capture.sv
module btn_capture
  import btn_pkg::*;
#(
  parameter int W      = 4,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [W-1:0]      eff_i,
  output logic              pressed_o,
  output logic [CODE_W-1:0] code_o
);
  btn_vec_t          eff_ext;
  logic              single_ok;
  logic [CODE_W-1:0] code_next;
  logic              pressed_q;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    eff_ext        = '0;
    eff_ext[W-1:0] = eff_i;
  end

  assign single_ok = is_single(eff_ext);
  assign code_next = CODE_W'(bit_index(eff_ext));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= 1'b0;
      code_q    <= '0;
    end else if (clear_i) begin
      pressed_q <= 1'b0;
      code_q    <= '0;
    end else if (!pressed_q && single_ok) begin
      pressed_q <= 1'b1;
      code_q    <= code_next;
    end
  end

  assign pressed_o = pressed_q;
  assign code_o    = code_q;

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pressed_q |-> code_q == '0); // R1
  AST_SINGLE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pressed_q && !clear_i && single_ok) |=> pressed_q); // R3
  AST_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (!pressed_q && !clear_i && !single_ok) |=> !pressed_q); // R4
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pressed_q && !clear_i) |=> (pressed_q && $stable(code_q))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!pressed_q && code_q == '0)); // R6
endmodule

// File: rtl/btn_latch_encoder.sv
module btn_latch_encoder #(
  parameter int NUM_BTN     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = (NUM_BTN > 1) ? $clog2(NUM_BTN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [NUM_BTN-1:0] btn_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pressed_o
);
  logic [NUM_BTN-1:0] btn_sync;
  logic [NUM_BTN-1:0] btn_mask;
  logic [NUM_BTN-1:0] btn_eff;

  btn_sync #(.W(NUM_BTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (btn_i),
    .q_o   (btn_sync)
  );

  btn_mask #(.W(NUM_BTN)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .sync_i  (btn_sync),
    .mask_o  (btn_mask)
  );

  // Held-over buttons are removed before the single-press test (R8).
  assign btn_eff = btn_sync & ~btn_mask;

  btn_capture #(.W(NUM_BTN), .CODE_W(CODE_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .eff_i     (btn_eff),
    .pressed_o (pressed_o),
    .code_o    (code_o)
  );
endmodule

// File: tb/tb_btn_latch_encoder.sv
module tb_btn_latch_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {pattern[6:3], expected pressed[2], expected code[1:0]}
  localparam logic [6:0] VEC [NV] = '{
    {4'b0001, 1'b1, 2'b00},
    {4'b0010, 1'b1, 2'b01},
    {4'b0100, 1'b1, 2'b10},
    {4'b1000, 1'b1, 2'b11},
    {4'b1100, 1'b0, 2'b00},
    {4'b1001, 1'b0, 2'b00},
    {4'b0111, 1'b0, 2'b00},
    {4'b1111, 1'b0, 2'b00},
    {4'b0000, 1'b0, 2'b00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear_i = 1'b0;
  logic [3:0] btn_i = 4'b0;
  logic [1:0] code_o;
  logic       pressed_o;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_latch_encoder dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
    .btn_i(btn_i), .code_o(code_o), .pressed_o(pressed_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_p, input logic [1:0] exp_c);
    tests++;
    if (pressed_o !== exp_p || code_o !== exp_c) begin
      fails++;
      $display("FAIL %s: pressed=%b code=%b expected pressed=%b code=%b",
               req, pressed_o, code_o, exp_p, exp_c);
    end
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    wait_n(1);
    clear_i = 1'b0;
  endtask

  task automatic release_and_clear();
    btn_i = 4'b0000;
    wait_n(4);
    do_clear();
    wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 reset state", 1'b0, 2'b00);

    // Table walk: R2 encoding, R4 multi-press rejection
    for (int i = 0; i < NV; i++) begin
      btn_i = VEC[i][6:3];
      wait_n(4);
      chk(VEC[i][2] ? "R2 lone press code" : "R4 multi press ignored",
          VEC[i][2], VEC[i][1:0]);
      release_and_clear();
    end

    // R3 latency: nothing after two edges, held after the third
    btn_i = 4'b0010;
    wait_n(2);
    chk("R3 not yet after two edges", 1'b0, 2'b00);
    wait_n(1);
    chk("R3 held on third edge", 1'b1, 2'b01);

    // R5 bounce and new presses ignored while held
    btn_i = 4'b0000; wait_n(3);
    btn_i = 4'b1000; wait_n(3);
    btn_i = 4'b0001; wait_n(3);
    chk("R5 held through bounce", 1'b1, 2'b01);

    // R6 clear empties the result on the next edge
    btn_i = 4'b0000;
    wait_n(4);
    clear_i = 1'b1;
    wait_n(1);
    chk("R6 cleared after one edge", 1'b0, 2'b00);
    // R6 press arriving while clear is high is not captured
    btn_i = 4'b0100;
    wait_n(4);
    chk("R6 no capture during clear", 1'b0, 2'b00);
    clear_i = 1'b0;
    wait_n(4);
    chk("R7 press held across clear masked", 1'b0, 2'b00);
    release_and_clear();

    // R7 held button across clear ignored until released
    btn_i = 4'b1000;
    wait_n(4);
    chk("R7 first press taken", 1'b1, 2'b11);
    do_clear();
    wait_n(5);
    chk("R7 still held after clear ignored", 1'b0, 2'b00);
    btn_i = 4'b0000;
    wait_n(4);
    chk("R7 release gives no press", 1'b0, 2'b00);
    btn_i = 4'b1000;
    wait_n(4);
    chk("R7 repress after release taken", 1'b1, 2'b11);
    release_and_clear();

    // R8 masked held button does not block a new lone press
    btn_i = 4'b0001;
    wait_n(4);
    do_clear();
    wait_n(2);
    chk("R8 cleared with button held", 1'b0, 2'b00);
    btn_i = 4'b0101;
    wait_n(4);
    chk("R8 new press beside masked button", 1'b1, 2'b10);
    release_and_clear();

    // R4 multi press then narrowed to a lone press is then accepted
    btn_i = 4'b1100;
    wait_n(4);
    chk("R4 pair ignored", 1'b0, 2'b00);
    btn_i = 4'b0100;
    wait_n(4);
    chk("R2 lone press after pair", 1'b1, 2'b10);
    release_and_clear();

    // R1 reset mid-hold returns to idle
    btn_i = 4'b0010;
    wait_n(4);
    rst_n = 1'b0;
    wait_n(1);
    chk("R1 reset clears held press", 1'b0, 2'b00);
    btn_i = 4'b0000;
    rst_n = 1'b1;
    wait_n(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule